// File: doc/BRIEF.md
# Output Clock Gating and Power-Down Sequencer

This block sits between a set of internal clock sources and the output pins of a clock generator. Each output passes its source through a gate. The gate closes when the output's enable bit is cleared, when a stop control that covers the output is active, or when the chip is being powered down. A gate opens or closes only while its source is low. Because of this, an output pulse is never shortened and no runt pulse can reach a pin. All sources are sampled as level signals in the domain of a fast sequencer clock `clk`.

An asynchronous active-low power-down input first passes through a synchronizer. A sequencer then drives the power-down. It closes every gate, waits until each output is confirmed low, and only then drops the oscillator and PLL enables and raises a done flag. When power-down is released, the sequencer turns the oscillator and PLLs back on. It then holds every output low for a fixed number of reference-clock rising edges before it lets them run. A separate tristate request turns the output drivers off.

Top module: `clk_gate_seq`

## Requirements
- R1: `pd_n` passes through a `SYNC_STAGES` flop synchronizer (default 2). The sequencer acts on the synchronized value only, so a change on `pd_n` reaches the sequencer state 3 `clk` edges later.
- R2: When the sequencer leaves the run state, an output that is high stays high until its source falls. From then on the output stays low. An output never falls while its source is still high.
- R3: `osc_en` and `pll_en` go low, and `pd_done` goes high, only after every gate is closed. While `osc_en` is low, all of `clk_out` is 0.
- R4: After the synchronized power-down is released, `osc_en` and `pll_en` return to 1 on the next edge. Outputs stay low until `WAKE_EDGES` rising edges of source `REF_IDX` have been counted. Outputs follow their gates from the next cycle on.
- R5: An output whose `out_en` bit is 0 is held low. An enable change takes effect only on a cycle in which that output's source is low. An output never rises unless its source was high.
- R6: While `cpu_stop_n` is 0, the outputs marked in `CPU_MASK` (default bits 2:0) stop low.
- R7: While `pci_stop_n` is 0, the outputs marked in `PCI_MASK` (default bits 5:4) stop low. Output 6, which is free-running, keeps toggling under this stop, but it still stops under power-down.
- R8: `out_oe` is the inverse of `tri_req`, registered one cycle. It is independent of power-down and gating.
- R9: After reset, `osc_en` and `pll_en` are 1, `pd_done` is 0 and `clk_out` is 0. The block performs the same `WAKE_EDGES` wait before any output runs.
- R10: If power-down is asserted again during the wake wait, the sequencer abandons the wait. It goes through the stop state to the off state, which raises `pd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; sources are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_OUT | Internal clock sources, one per output |
| out_en | input | N_OUT | Per-output enable bits from configuration |
| cpu_stop_n | input | 1 | Active-low stop for the CPU-domain outputs |
| pci_stop_n | input | 1 | Active-low stop for the stoppable PCI outputs |
| tri_req | input | 1 | Request to place all outputs in high impedance |
| clk_out | output | N_OUT | Gated output clocks |
| out_oe | output | 1 | Output driver enable (0 = high impedance) |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| pd_done | output | 1 | All outputs held low and sources switched off |

## Verification
The hardest situation to reach is a power-down that arrives while the sequencer is still counting reference edges after a wake-up. The window lasts only `WAKE_EDGES` reference periods. The bench releases power-down and waits a fixed number of cycles, shorter than that window, before it lowers `pd_n` again. It also drives sources with several unrelated half-periods, so that stop requests land while some outputs are high and others are low. A behavioural model is compared with every output on every cycle.

// File: rtl/clk_gate_pkg.sv
// Shared types for the output clock gating and power-down sequencer.
package clk_gate_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,  // outputs follow their gates
        SEQ_STOP = 2'd1,  // gates closing, sources still on
        SEQ_OFF  = 2'd2,  // sources disabled, all outputs low
        SEQ_WAKE = 2'd3   // sources on, counting reference edges
    } seq_state_t;

endpackage

// File: rtl/pd_sync.sv
// Multi-flop synchronizer for the asynchronous active-low power-down input.
// Assumes the input may change at any time; it resets to the inactive (high) level.
module pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gate_cell.sv
// Glitch-free gate for one output clock. The gate state may change only
// while the source is low; the output is registered from source AND gate.
// Assumes the source is a level signal sampled on clk.
module gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic want,
    output logic clk_out,
    output logic open
);

    logic gate_q;
    logic gate_nxt;
    logic out_q;

    // Accept a new gate request only while the source is low
    always_comb gate_nxt = src ? gate_q : want;

    // Hold the gate state and drive the registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            gate_q <= gate_nxt;
            out_q  <= src & gate_nxt;
        end
    end

    assign clk_out = out_q;
    assign open    = gate_q;

endmodule

// File: rtl/pwr_seq.sv
// Power-down / power-up sequencer. It closes the gates, waits for all of
// them to close, then turns the sources off. On wake it turns them back on
// and counts reference rising edges before it allows the gates to open.
// Assumes ref_src toggles only while osc_en is high.
module pwr_seq
    import clk_gate_pkg::*;
#(
    parameter int WAKE_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_sync_n,
    input  logic ref_src,
    input  logic all_closed,
    output logic run,
    output logic osc_en,
    output logic pll_en,
    output logic pd_done
);

    localparam int CNT_W = $clog2(WAKE_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_EDGES - 1);

    seq_state_t        state_q, state_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              ref_q;
    logic              ref_rise;

    // Detect a reference rising edge between samples
    always_comb ref_rise = ref_src & ~ref_q;

    // Next-state decision
    always_comb begin
        state_nxt = state_q;
        case (state_q)
            SEQ_RUN:  if (!pd_sync_n) state_nxt = SEQ_STOP;
            SEQ_STOP: if (all_closed) state_nxt = SEQ_OFF;
            SEQ_OFF:  if (pd_sync_n)  state_nxt = SEQ_WAKE;
            SEQ_WAKE: begin
                if (!pd_sync_n)                    state_nxt = SEQ_STOP;
                else if (ref_rise && cnt_q == LAST) state_nxt = SEQ_RUN;
            end
            default:  state_nxt = SEQ_STOP;
        endcase
    end

    // State, wake counter and reference history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAKE;
            cnt_q   <= '0;
            ref_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            ref_q   <= ref_src;
            if (state_q != SEQ_WAKE) cnt_q <= '0;
            else if (ref_rise)       cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run     = (state_q == SEQ_RUN);
    assign osc_en  = (state_q != SEQ_OFF);
    assign pll_en  = (state_q != SEQ_OFF);
    assign pd_done = (state_q == SEQ_OFF);

endmodule

// File: rtl/clk_gate_seq.sv
// Top of the output clock gating and power-down sequencer. One gate cell
// per output; each gate's request combines its enable bit, the stop
// controls selected by the mask parameters, and the sequencer run flag.
// Assumes all sources are level signals sampled on clk.
module clk_gate_seq #(
    parameter int               N_OUT       = 8,
    parameter logic [N_OUT-1:0] CPU_MASK    = 8'b0000_0111,
    parameter logic [N_OUT-1:0] PCI_MASK    = 8'b0011_0000,
    parameter int               REF_IDX     = 7,
    parameter int               WAKE_EDGES  = 16,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic [N_OUT-1:0] src_clk,
    input  logic [N_OUT-1:0] out_en,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             tri_req,
    output logic [N_OUT-1:0] clk_out,
    output logic             out_oe,
    output logic             osc_en,
    output logic             pll_en,
    output logic             pd_done
);

    logic             pd_s_n;
    logic             run;
    logic [N_OUT-1:0] want;
    logic [N_OUT-1:0] gate_open;
    logic             oe_q;

    pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (pd_n),
        .sync_n  (pd_s_n)
    );

    pwr_seq #(.WAKE_EDGES(WAKE_EDGES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_sync_n  (pd_s_n),
        .ref_src    (src_clk[REF_IDX]),
        .all_closed (~|gate_open),
        .run        (run),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .pd_done    (pd_done)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // Gate request for this output
        always_comb want[i] = out_en[i] & run
                            & ~(CPU_MASK[i] & ~cpu_stop_n)
                            & ~(PCI_MASK[i] & ~pci_stop_n);

        gate_cell u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_clk[i]),
            .want    (want[i]),
            .clk_out (clk_out[i]),
            .open    (gate_open[i])
        );
    end

    // Register the driver enable from the tristate request
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b1;
        else        oe_q <= ~tri_req;
    end

    assign out_oe = oe_q;

endmodule

// File: rtl/clk_gate_seq_chk.sv
// Assertion checker for clk_gate_seq, attached with bind.
module clk_gate_seq_chk #(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] src_clk,
    input logic [N_OUT-1:0] clk_out,
    input logic             tri_req,
    input logic             out_oe,
    input logic             osc_en,
    input logic             pd_done
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_bit
        // R2
        fall_src_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clk_out[i]) |-> !$past(src_clk[i]));
        // R5
        rise_src_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_out[i]) |-> $past(src_clk[i]));
    end

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (clk_out == '0));
    // R3
    done_prior_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_done) |-> ($past(clk_out) == '0));
    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tri_req |=> !out_oe);
    // R8
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tri_req |=> out_oe);

endmodule

bind clk_gate_seq clk_gate_seq_chk #(.N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_clk (src_clk),
    .clk_out (clk_out),
    .tri_req (tri_req),
    .out_oe  (out_oe),
    .osc_en  (osc_en),
    .pd_done (pd_done)
);

// File: tb/clk_gate_seq_test.sv
// Bench: behavioural per-cycle model compared with every output, plus directed checks.
module clk_gate_seq_test;

    localparam int N   = 8;
    localparam int WE  = 16;
    localparam int REF = 7;
    localparam logic [N-1:0] CM = 8'b0000_0111;
    localparam logic [N-1:0] PM = 8'b0011_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic [N-1:0] src = '0;
    logic [N-1:0] en = '1;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic tri_req = 1'b0;
    logic [N-1:0] clk_out;
    logic out_oe, osc_en, pll_en, pd_done;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    clk_gate_seq uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .src_clk(src), .out_en(en),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .tri_req(tri_req),
        .clk_out(clk_out), .out_oe(out_oe), .osc_en(osc_en), .pll_en(pll_en),
        .pd_done(pd_done)
    );

    // Reference model state: 0 run, 1 stopping, 2 off, 3 waking
    int m_st = 3;
    int m_cnt = 0;
    bit m_s1 = 1, m_s2 = 1, m_refp = 0, m_oe = 1;
    bit m_gate[N];
    bit m_out[N];
    int src_cnt[N];

    function automatic logic [N-1:0] m_outv();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_out[i];
        return v;
    endfunction

    // Model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 3; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_refp = 0; m_oe = 1;
            for (int i = 0; i < N; i++) begin m_gate[i] = 0; m_out[i] = 0; end
        end else begin
            bit run, closed, rise, w, gn;
            int nst;
            run = (m_st == 0);
            closed = 1;
            for (int i = 0; i < N; i++) if (m_gate[i]) closed = 0;
            rise = src[REF] && !m_refp;
            nst = m_st;
            case (m_st)
                0: if (!m_s2) nst = 1;
                1: if (closed) nst = 2;
                2: if (m_s2) nst = 3;
                default: if (!m_s2) nst = 1; else if (rise && m_cnt == WE - 1) nst = 0;
            endcase
            if (m_st != 3) m_cnt = 0; else if (rise) m_cnt++;
            for (int i = 0; i < N; i++) begin
                w = en[i] && run && !(CM[i] && !cpu_stop_n) && !(PM[i] && !pci_stop_n);
                gn = src[i] ? m_gate[i] : w;
                m_out[i] = src[i] && gn;
                m_gate[i] = gn;
            end
            m_s2 = m_s1; m_s1 = pd_n; m_refp = src[REF]; m_oe = !tri_req; m_st = nst;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare on falling edge, then advance the source generators
    always @(negedge clk) begin
        if (rst_n) begin
            check(clk_out === m_outv(), cur_req, "clk_out", 32'(clk_out), 32'(m_outv()));
            check(osc_en === (m_st != 2), cur_req, "osc_en", 32'(osc_en), 32'(m_st != 2));
            check(pll_en === (m_st != 2), cur_req, "pll_en", 32'(pll_en), 32'(m_st != 2));
            check(pd_done === (m_st == 2), cur_req, "pd_done", 32'(pd_done), 32'(m_st == 2));
            check(out_oe === m_oe, "R8", "out_oe", 32'(out_oe), 32'(m_oe));
        end
        for (int i = 0; i < N; i++) begin
            if (m_st == 2) begin src[i] <= 1'b0; src_cnt[i] = 0; end
            else begin
                src_cnt[i]++;
                if (src_cnt[i] >= (i % 4) + 2) begin src_cnt[i] = 0; src[i] <= ~src[i]; end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int tog;
    logic [N-1:0] prev;

    task automatic run_count(input int cyc, input int bitn, output int n);
        logic p;
        n = 0;
        @(negedge clk); p = clk_out[bitn];
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            if (clk_out[bitn] !== p) n++;
            p = clk_out[bitn];
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(clk_out === '0 && osc_en && pll_en && !pd_done, "R9", "reset state",
              {clk_out, 4'b0, osc_en, pll_en, pd_done}, {8'h00, 4'b0, 3'b110});
        cur_req = "R4 R9";
        run_count(250, 0, tog);
        check(tog > 0, "R9", "output 0 running after wake", tog, 1);

        cur_req = "R5";
        @(negedge clk); en = 8'hF0;
        repeat (4) @(negedge clk);
        run_count(60, 1, tog);
        check(tog == 0, "R5", "disabled output 1 toggles", tog, 0);
        en = '1;
        repeat (40) @(negedge clk);

        cur_req = "R6";
        cpu_stop_n = 1'b0;
        repeat (6) @(negedge clk);
        run_count(60, 2, tog);
        check(tog == 0, "R6", "cpu-stopped output 2 toggles", tog, 0);
        run_count(30, 3, tog);
        check(tog > 0, "R6", "unmasked output 3 toggles", tog, 1);
        cpu_stop_n = 1'b1;
        repeat (20) @(negedge clk);

        cur_req = "R7";
        pci_stop_n = 1'b0;
        repeat (6) @(negedge clk);
        run_count(60, 4, tog);
        check(tog == 0, "R7", "pci-stopped output 4 toggles", tog, 0);
        run_count(60, 6, tog);
        check(tog > 0, "R7", "free-running output 6 toggles", tog, 1);
        pci_stop_n = 1'b1;
        repeat (20) @(negedge clk);

        cur_req = "R8";
        tri_req = 1'b1;
        @(negedge clk);
        check(out_oe === 1'b0, "R8", "oe under tristate", out_oe, 0);
        tri_req = 1'b0;
        @(negedge clk);
        check(out_oe === 1'b1, "R8", "oe released", out_oe, 1);

        cur_req = "R1 R2 R3";
        pd_n = 1'b0;
        repeat (2) @(negedge clk);
        check(osc_en === 1'b1, "R1", "osc still on before sync", osc_en, 1);
        repeat (60) @(negedge clk);
        check(pd_done === 1'b1 && clk_out === '0, "R3", "powered down",
              {clk_out, pd_done}, 9'h001);
        check(osc_en === 1'b0, "R3", "osc off", osc_en, 0);

        cur_req = "R4";
        pd_n = 1'b1;
        repeat (4) @(negedge clk);
        check(osc_en === 1'b1 && clk_out === '0, "R4", "waking, outputs held",
              {clk_out, osc_en}, 9'h001);
        repeat (250) @(negedge clk);

        cur_req = "R10";
        pd_n = 1'b0;
        repeat (60) @(negedge clk);
        pd_n = 1'b1;
        repeat (30) @(negedge clk);
        pd_n = 1'b0;
        repeat (40) @(negedge clk);
        check(pd_done === 1'b1, "R10", "abort during wake", pd_done, 1);
        pd_n = 1'b1;
        cur_req = "R4";
        repeat (250) @(negedge clk);
        check(osc_en === 1'b1 && !pd_done, "R4", "running again",
              {osc_en, pd_done}, 2'b10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule